// File: doc/BRIEF.md
# Bus-Mapped 32x32 Multiplier

This peripheral multiplies two 32-bit operands and returns a 64-bit product, treating the operands either as unsigned integers or as two's-complement signed integers. A small CPU talks to it over a plain 16-bit register bus with a write strobe, a read strobe, a byte address and a 16-bit data path. Each operand is built from two 16-bit halves, each written to its own address. Which address receives the low half of the first operand decides whether the next multiply is signed. Writing the high half of the second operand starts the computation.

The multiply runs as a shift-add loop that handles one multiplier bit per clock. It takes exactly 32 cycles, and a `busy` output is high for that whole time. Software polls `busy` and then reads the product as four 16-bit words. The product register changes only in the cycle the loop finishes, so a read during the loop returns the previous result. Bus writes made while `busy` is high are dropped.

Top module: `mmio_mul32`

## Requirements
- R1: After reset, all four product words read 0, `busy` is 0, both operands are 0 and the mode is unsigned.
- R2: A write to 0x140 loads operand A with the 16-bit data zero-extended to 32 bits and selects unsigned mode. A write to 0x144 does the same and selects signed mode.
- R3: A write to 0x142 or 0x146 replaces bits 31:16 of operand A. It keeps bits 15:0 and leaves the mode unchanged.
- R4: A write to 0x150 loads operand B with the data zero-extended. It starts no multiply, `busy` stays 0 and the product already present stays readable.
- R5: A write to 0x152 replaces bits 31:16 of operand B and starts a multiply. `busy` reads 1 after that clock edge and stays 1 for exactly 32 cycles.
- R6: In unsigned mode the product equals the 64-bit unsigned product of the two operands.
- R7: In signed mode the product equals the 64-bit two's-complement product of the sign-extended operands, so the top word carries the sign.
- R8: While `rd_en` is 1, address 0x154 reads product bits 15:0, 0x156 reads bits 31:16, 0x158 reads bits 47:32 and 0x15A reads bits 63:48. Every other address, and any cycle with `rd_en` at 0, reads 0.
- R9: While `busy` is 1, writes to any address leave both operands and the mode unchanged and start nothing.
- R10: The product register changes only in the cycle the multiply completes. While `busy` is 1, reads return the previous product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe; `rdata` is 0 when low |
| addr | input | 9 | Byte address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| busy | output | 1 | High while the multiply loop runs |

## Verification
On every cycle the bound checker watches the handshake and hold properties. A start must raise `busy`, and `busy` must last exactly 32 cycles, counted by the checker's own counter. No start may occur while `busy` is high, and the product may change only on completion. A high-half write must keep the low half of operand A and the mode, and a low-half write of operand B must clear its upper half. Whether the arithmetic is right, and whether the mode is selected correctly, can only be shown by the bench. It sweeps a grid of boundary operands in both modes, runs pseudo-random pairs, and checks that writes made during a run are dropped, by using the surviving operands in a later run.

// File: rtl/mmul_pkg.sv
package mmul_pkg;
  localparam int OP_W   = 32;
  localparam int HALF_W = OP_W / 2;
  localparam int PROD_W = 2 * OP_W;
  localparam int ADDR_W = 9;

  typedef enum logic {MODE_UNS = 1'b0, MODE_SGN = 1'b1} mul_mode_e;

  localparam logic [ADDR_W-1:0] A_OP1_LO_U = 9'h140;
  localparam logic [ADDR_W-1:0] A_OP1_HI_U = 9'h142;
  localparam logic [ADDR_W-1:0] A_OP1_LO_S = 9'h144;
  localparam logic [ADDR_W-1:0] A_OP1_HI_S = 9'h146;
  localparam logic [ADDR_W-1:0] A_OP2_LO   = 9'h150;
  localparam logic [ADDR_W-1:0] A_OP2_HI   = 9'h152;
  localparam logic [ADDR_W-1:0] A_PROD0    = 9'h154;
  localparam logic [ADDR_W-1:0] A_PROD1    = 9'h156;
  localparam logic [ADDR_W-1:0] A_PROD2    = 9'h158;
  localparam logic [ADDR_W-1:0] A_PROD3    = 9'h15A;

  // Correction that turns an unsigned product into a signed one, modulo 2^PROD_W:
  // a_s*b_s = a*b - 2^OP_W*(a_msb*b + b_msb*a)
  function automatic logic [PROD_W-1:0] sign_fix(logic [OP_W-1:0] a,
                                                 logic [OP_W-1:0] b,
                                                 mul_mode_e mode);
    logic [PROD_W-1:0] fix;
    fix = '0;
    if (mode == MODE_SGN) begin
      if (a[OP_W-1]) fix = fix + {b, {OP_W{1'b0}}};
      if (b[OP_W-1]) fix = fix + {a, {OP_W{1'b0}}};
    end
    return fix;
  endfunction

  function automatic logic [HALF_W-1:0] prod_word(logic [PROD_W-1:0] p, int idx);
    return p[idx*HALF_W +: HALF_W];
  endfunction
endpackage

// File: rtl/mmul_opregs.sv
module mmul_opregs import mmul_pkg::*; #(
  parameter int OW = OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [OW/2-1:0]   wdata,
  input  logic              busy,
  output logic [OW-1:0]     op1,
  output logic [OW-1:0]     op2,
  output mul_mode_e         mode,
  output logic              start,
  output logic [OW-1:0]     op2_load
);
  localparam int HW = OW / 2;

  logic wr_ok;
  assign wr_ok    = wr_en && !busy;
  assign start    = wr_ok && (addr == A_OP2_HI);
  assign op2_load = {wdata, op2[HW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1  <= '0;
      op2  <= '0;
      mode <= MODE_UNS;
    end else if (wr_ok) begin
      case (addr)
        A_OP1_LO_U: begin op1 <= OW'(wdata); mode <= MODE_UNS; end
        A_OP1_LO_S: begin op1 <= OW'(wdata); mode <= MODE_SGN; end
        A_OP1_HI_U,
        A_OP1_HI_S: op1[OW-1:HW] <= wdata;
        A_OP2_LO:   op2 <= OW'(wdata);
        A_OP2_HI:   op2[OW-1:HW] <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mmul_engine.sv
module mmul_engine import mmul_pkg::*; #(
  parameter int OW = OP_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OW-1:0]  a,
  input  logic [OW-1:0]  b,
  input  mul_mode_e      mode,
  output logic           busy,
  output logic           done,
  output logic [2*OW-1:0] product
);
  localparam int PW = 2 * OW;
  localparam int CW = $clog2(OW);
  localparam logic [CW-1:0] LAST = CW'(OW - 1);

  logic [OW-1:0] mcand, mplr_orig, mplr;
  logic [PW-1:0] acc, addend, acc_nx;
  logic [CW-1:0] cnt;
  mul_mode_e     mode_q;

  always_comb begin
    addend = mplr[0] ? (PW'(mcand) << cnt) : '0;
    acc_nx = acc + addend;
    done   = busy && (cnt == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      mcand     <= '0;
      mplr_orig <= '0;
      mplr      <= '0;
      acc       <= '0;
      mode_q    <= MODE_UNS;
      product   <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      cnt       <= '0;
      mcand     <= a;
      mplr_orig <= b;
      mplr      <= b;
      acc       <= '0;
      mode_q    <= mode;
    end else if (busy) begin
      acc  <= acc_nx;
      mplr <= mplr >> 1;
      cnt  <= cnt + 1'b1;
      if (done) begin
        busy    <= 1'b0;
        product <= acc_nx - sign_fix(mcand, mplr_orig, mode_q);
      end
    end
  end
endmodule

// File: rtl/mmul_rdport.sv
module mmul_rdport import mmul_pkg::*; (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PROD_W-1:0] product,
  output logic [HALF_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_PROD0: rdata = prod_word(product, 0);
        A_PROD1: rdata = prod_word(product, 1);
        A_PROD2: rdata = prod_word(product, 2);
        A_PROD3: rdata = prod_word(product, 3);
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mmio_mul32.sv
module mmio_mul32 import mmul_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] rdata,
  output logic              busy
);
  logic [OP_W-1:0]   op1_w, op2_w, op2_load_w;
  logic [PROD_W-1:0] prod_w;
  logic              start_w, done_w;
  mul_mode_e         mode_w;

  mmul_opregs #(.OW(OP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(busy), .op1(op1_w), .op2(op2_w), .mode(mode_w),
    .start(start_w), .op2_load(op2_load_w)
  );

  mmul_engine #(.OW(OP_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start_w), .a(op1_w), .b(op2_load_w),
    .mode(mode_w), .busy(busy), .done(done_w), .product(prod_w)
  );

  mmul_rdport u_rd (
    .rd_en(rd_en), .addr(addr), .product(prod_w), .rdata(rdata)
  );
endmodule

// File: rtl/mmio_mul32_chk.sv
module mmio_mul32_chk import mmul_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              start,
  input logic              done,
  input logic [OP_W-1:0]   op1,
  input logic [OP_W-1:0]   op2,
  input mul_mode_e         mode,
  input logic [PROD_W-1:0] product
);
  localparam int HW = OP_W / 2;
  localparam int BW = $clog2(OP_W) + 1;
  localparam logic [BW-1:0] BLAST = BW'(OP_W - 1);

  logic [BW-1:0] bcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bcnt <= '0;
    else if (start) bcnt <= '0;
    else if (busy)  bcnt <= bcnt + 1'b1;
  end

  logic hi1_wr, lo2_wr;
  assign hi1_wr = wr_en && !busy && (addr == A_OP1_HI_U || addr == A_OP1_HI_S);
  assign lo2_wr = wr_en && !busy && (addr == A_OP2_LO);

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R5
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt < BLAST) |=> busy); // R5
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt == BLAST) |=> !busy); // R5
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R9
  AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op1) && $stable(op2) && $stable(mode))); // R9
  AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(product)); // R10
  AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hi1_wr |=> ($stable(op1[HW-1:0]) && $stable(mode))); // R3
  AST_LO2_CLEARS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    lo2_wr |=> (op2[OP_W-1:HW] == '0 && !busy)); // R4
endmodule

bind mmio_mul32 mmio_mul32_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .busy(busy),
  .start(start_w), .done(done_w), .op1(op1_w), .op2(op2_w), .mode(mode_w),
  .product(prod_w)
);

// File: tb/sim_mmio_mul32.sv
`timescale 1ns/1ps
module sim_mmio_mul32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mmio_mul32 u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic rd_prod(output logic [63:0] p);
    logic [15:0] w0, w1, w2, w3;
    rd(9'h154, w0); rd(9'h156, w1); rd(9'h158, w2); rd(9'h15A, w3);
    p = {w3, w2, w1, w0};
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] model(logic [31:0] a, logic [31:0] b, bit sgn);
    logic signed [63:0] sa, sb;
    if (sgn) begin
      sa = 64'($signed(a));
      sb = 64'($signed(b));
      return sa * sb;
    end
    return {32'h0, a} * {32'h0, b};
  endfunction

  task automatic mul_run(logic [31:0] a, logic [31:0] b, bit sgn);
    int n;
    logic [63:0] p;
    wr(sgn ? 9'h144 : 9'h140, a[15:0]);
    wr(sgn ? 9'h146 : 9'h142, a[31:16]);
    wr(9'h150, b[15:0]);
    wr(9'h152, b[31:16]);
    wait_idle(n);
    chk("R5 busy length", 64'(n), 64'd32);
    rd_prod(p);
    chk(sgn ? "R7 signed product" : "R6 unsigned product", p, model(a, b, sgn));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] p, p_prev;
    logic [15:0] d;
    logic [31:0] lf;
    logic [31:0] grid [8];
    int n;
    grid[0] = 32'h0;        grid[1] = 32'h1;        grid[2] = 32'h0000FFFF;
    grid[3] = 32'h00010000; grid[4] = 32'h7FFFFFFF; grid[5] = 32'h80000000;
    grid[6] = 32'hFFFFFFFF; grid[7] = 32'h12345678;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy after reset", 64'(busy), 64'd0);
    rd_prod(p);
    chk("R1 product after reset", p, 64'd0);
    // R1: unsigned mode and zero operand A after reset
    wr(9'h142, 16'hFFFF);
    wr(9'h150, 16'h0002);
    wr(9'h152, 16'h0000);
    wait_idle(n);
    rd_prod(p);
    chk("R1 default unsigned mode", p, 64'h0000_0001_FFFE_0000);

    // R6 / R7: grid sweep in both modes
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          mul_run(grid[i], grid[j], s[0]);

    // R6 / R7: pseudo-random pairs
    lf = 32'hACE1_2468;
    for (int k = 0; k < 40; k++) begin
      logic [31:0] ra, rb;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ra = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      rb = lf ^ 32'h5A5A_1234;
      mul_run(ra, rb, k[0]);
    end

    // R2: low write clears upper half of A (A was loaded with upper bits set)
    mul_run(32'hFFFF_FFFF, 32'h1, 1'b0);
    wr(9'h140, 16'h0003);
    wr(9'h150, 16'h0002);
    wr(9'h152, 16'h0000);
    wait_idle(n);
    rd_prod(p);
    chk("R2 unsigned low write clears upper", p, 64'd6);
    wr(9'h144, 16'h8000);
    wr(9'h150, 16'hFFFF);
    wr(9'h152, 16'hFFFF);
    wait_idle(n);
    rd_prod(p);
    chk("R2 signed low write zero-extends", p, 64'hFFFF_FFFF_FFFF_8000);

    // R3: high write keeps low half and mode
    wr(9'h144, 16'h0001);
    wr(9'h142, 16'hFFFF);
    wr(9'h150, 16'h0002);
    wr(9'h152, 16'h0000);
    wait_idle(n);
    rd_prod(p);
    chk("R3 hi write keeps signed mode", p, model(32'hFFFF_0001, 32'h2, 1'b1));
    wr(9'h140, 16'h0005);
    wr(9'h146, 16'h8000);
    wr(9'h150, 16'h0003);
    wr(9'h152, 16'h0000);
    wait_idle(n);
    rd_prod(p);
    chk("R3 hi write keeps unsigned mode", p, model(32'h8000_0005, 32'h3, 1'b0));

    // R9 / R10: activity during a run
    mul_run(32'h1111_2222, 32'h3, 1'b0);
    p_prev = model(32'h1111_2222, 32'h3, 1'b0);
    wr(9'h140, 16'h5678);
    wr(9'h142, 16'h1234);
    wr(9'h150, 16'h0003);
    wr(9'h152, 16'h0000);
    chk("R5 busy after start", 64'(busy), 64'd1);
    rd(9'h154, d);
    chk("R10 old product low word while busy", 64'(d), {48'h0, p_prev[15:0]});
    rd(9'h15A, d);
    chk("R10 old product top word while busy", 64'(d), {48'h0, p_prev[63:48]});
    wr(9'h144, 16'hAAAA);
    wr(9'h150, 16'h0009);
    wr(9'h152, 16'h0007);
    wait_idle(n);
    rd_prod(p);
    chk("R9 writes during run ignored", p, model(32'h1234_5678, 32'h3, 1'b0));
    wr(9'h150, 16'h0005);
    chk("R4 low write of B does not start", 64'(busy), 64'd0);
    rd_prod(p);
    chk("R4 product kept after B low write", p, model(32'h1234_5678, 32'h3, 1'b0));
    wr(9'h152, 16'h0000);
    wait_idle(n);
    rd_prod(p);
    chk("R9 operand A and mode survived run", p, model(32'h1234_5678, 32'h5, 1'b0));

    // R8: unmapped addresses and idle strobe
    rd(9'h140, d);
    chk("R8 operand address reads zero", 64'(d), 64'd0);
    rd(9'h15C, d);
    chk("R8 address past product reads zero", 64'(d), 64'd0);
    rd(9'h155, d);
    chk("R8 odd address reads zero", 64'(d), 64'd0);
    @(negedge clk);
    addr = 9'h154; rd_en = 1'b0;
    #1 chk("R8 no strobe reads zero", 64'(rdata), 64'd0);
    rd(9'h154, d);
    chk("R8 word 0 mapping", 64'(d), {48'h0, p[15:0]});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule